// File: doc/BRIEF.md
# Bit-Order Configurable Serial Register Slave

This block is a serial-port slave that gives a host read and write access to a bank of 128 eight-bit registers. The host lowers an active-low select, clocks in an instruction byte with a read/write flag and a 7-bit register address, and then moves any number of data bytes while the select stays low. The shared data line is split into an input, an output and an output enable. A pad or the host model joins them into one wire.

Bit 6 of register 0x00 controls the transfer format. When it is clear, bits travel most-significant first and the register address steps down after each data byte. When it is set, bits travel least-significant first and the address steps up. In both cases the address stops at its limit.

The serial pins are oversampled by a fast system clock. Each SCLK half period must last at least SYNC_STAGES + 2 system clock cycles. Input bits are taken on the rising SCLK edge, and read data is launched on the falling edge.

Top module: `spi_rb_slave`

## Requirements
- R1: After reset every register reads 0x00, the block works most-significant first, and `spi_doe` is low.
- R2: The instruction byte holds a read/write flag (1 = read, 0 = write) and a 7-bit address. In most-significant-first mode the flag is the first bit on the line, followed by address bits 6 down to 0.
- R3: In most-significant-first mode, data bit 7 goes first and bit 0 goes last. Input bits are sampled on rising SCLK, and read bits are launched on falling SCLK.
- R4: When bit 6 of register 0x00 is 1, the instruction is sent as address bits 0 up to 6 with the read/write flag last. Data goes bit 0 first up to bit 7.
- R5: In most-significant-first mode, the instruction address names the first data byte, and each later byte in the same frame uses the next lower address.
- R6: In least-significant-first mode, each later byte in the same frame uses the next higher address.
- R7: When the address is stepping down, once it reaches 0x00 it stays there for all further bytes of the frame.
- R8: When the address is stepping up, once it reaches 0x7F it stays there for all further bytes of the frame.
- R9: A write to bit 6 of register 0x00 changes the bit order and step direction only from the next frame. The rest of the current frame keeps the old format.
- R10: Raising the select partway through a byte throws that byte away and clears the bit counter. A partial write byte is never stored, and bytes completed earlier in the frame are kept.
- R11: `spi_doe` is high only during the data bytes of a read while the select is low. It stays low during the instruction, during writes and between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select that frames a transfer |
| spi_din | input | 1 | Data line as seen from the host side |
| spi_dout | output | 1 | Read data driven toward the host |
| spi_doe | output | 1 | Output enable for the shared data line |

## Verification
The bench writes in one bit order and reads back in the other. A design that reversed bits the same way on both paths would still pass a round trip in a single order, but fails this check. Bursts are run into address 0x00 going down and into 0x7F going up. A counter that wrapped would overwrite register 0x7F or register 0x00 instead of the limit register. In another frame, the mode bit is written in the middle of the frame and the next byte is checked. A design that applied the new mode at once would store that byte bit-reversed in the wrong register. Frames are also cut off partway through a data byte and partway through an instruction. A design that kept stale bit counts or committed partial bytes would corrupt a neighbouring register or misread the next frame.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int AW        = 7;
  localparam int DW        = 8;
  localparam int DEPTH     = 1 << AW;
  localparam int BCW       = $clog2(DW);
  localparam int MODE_REG  = 0;
  localparam int MODE_BIT  = 6;

  typedef logic [AW-1:0]  addr_t;
  typedef logic [DW-1:0]  byte_t;
  typedef logic [BCW-1:0] bcnt_t;

  localparam addr_t ADDR_MAX = '1;
  localparam bcnt_t BCNT_LAST = '1;

  // Address for the next byte of a burst; holds at either limit.
  function automatic addr_t step_addr(addr_t a, logic up);
    if (up) return (a == ADDR_MAX) ? a : a + addr_t'(1);
    else    return (a == '0)       ? a : a - addr_t'(1);
  endfunction

  // Bit position of a data byte that goes out as the n-th bit on the line.
  function automatic bcnt_t line_bit(bcnt_t n, logic lsb_first);
    return lsb_first ? n : ~n;
  endfunction

  // Put a fresh line bit into the shift register for the active order.
  function automatic byte_t shift_in(byte_t sh, logic b, logic lsb_first);
    return lsb_first ? {b, sh[DW-1:1]} : {sh[DW-2:0], b};
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic din_s
);
  logic [STAGES-1:0] sclk_sr, csn_sr, din_sr;
  logic              sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr   <= '0;
      csn_sr    <= '1;
      din_sr    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_sr   <= {sclk_sr[STAGES-2:0], sclk};
      csn_sr    <= {csn_sr[STAGES-2:0], csn};
      din_sr    <= {din_sr[STAGES-2:0], din};
      sclk_prev <= sclk_sr[STAGES-1];
    end
  end

  assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_prev;
  assign sclk_fall = ~sclk_sr[STAGES-1] & sclk_prev;
  assign cs_active = ~csn_sr[STAGES-1];
  assign din_s     = din_sr[STAGES-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
  import spi_rb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  byte_t wr_data,
  input  addr_t rd_addr,
  output byte_t rd_data,
  output logic  mode_lsb
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign mode_lsb = mem[MODE_REG][MODE_BIT];
endmodule

// File: rtl/spi_rb_ctl.sv
module spi_rb_ctl
  import spi_rb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  cs_active,
  input  logic  din_s,
  input  logic  mode_lsb,
  input  byte_t rd_data,
  output logic  wr_en,
  output byte_t wr_data,
  output addr_t addr,
  output logic  dout,
  output logic  doe,
  output logic  byte_done,
  output logic  data_phase,
  output logic  lsb_xfer
);
  byte_t sh;
  byte_t sh_next;
  bcnt_t bit_cnt;
  logic  rd_flag;

  assign sh_next   = shift_in(sh, din_s, lsb_xfer);
  assign byte_done = cs_active & sclk_rise & (bit_cnt == BCNT_LAST);
  assign wr_en     = byte_done & data_phase & ~rd_flag;
  assign wr_data   = sh_next;
  assign doe       = cs_active & data_phase & rd_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      bit_cnt    <= '0;
      data_phase <= 1'b0;
      rd_flag    <= 1'b0;
      addr       <= '0;
      lsb_xfer   <= 1'b0;
      dout       <= 1'b0;
    end else if (!cs_active) begin
      bit_cnt    <= '0;
      data_phase <= 1'b0;
      rd_flag    <= 1'b0;
      lsb_xfer   <= mode_lsb;
      dout       <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sh      <= sh_next;
        bit_cnt <= bit_cnt + bcnt_t'(1);
        if (bit_cnt == BCNT_LAST) begin
          if (!data_phase) begin
            data_phase <= 1'b1;
            rd_flag    <= sh_next[DW-1];
            addr       <= sh_next[AW-1:0];
          end else begin
            addr <= step_addr(addr, lsb_xfer);
          end
        end
      end
      if (sclk_fall && data_phase && rd_flag)
        dout <= rd_data[line_bit(bit_cnt, lsb_xfer)];
    end
  end
endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_din,
  output logic spi_dout,
  output logic spi_doe
);
  import spi_rb_pkg::*;

  logic  sclk_rise, sclk_fall, cs_active, din_s;
  logic  wr_en, mode_lsb, byte_done, data_phase, lsb_xfer;
  byte_t wr_data, rd_data;
  addr_t addr;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .csn(spi_csn), .din(spi_din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_active(cs_active), .din_s(din_s)
  );

  spi_rb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_active(cs_active), .din_s(din_s), .mode_lsb(mode_lsb), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .addr(addr), .dout(spi_dout), .doe(spi_doe),
    .byte_done(byte_done), .data_phase(data_phase), .lsb_xfer(lsb_xfer)
  );

  spi_rb_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_data(rd_data), .mode_lsb(mode_lsb)
  );
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_active,
  input logic          spi_doe,
  input logic          byte_done,
  input logic          data_phase,
  input logic          lsb_xfer,
  input logic          wr_en,
  input logic [AW-1:0] addr
);
  localparam logic [AW-1:0] TOP = '1;

  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_doe |-> cs_active); // R11
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && data_phase && !lsb_xfer) |=> (addr <= $past(addr))); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && data_phase && lsb_xfer) |=> (addr >= $past(addr))); // R6
  AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && data_phase && !lsb_xfer && addr == '0) |=> (addr == '0)); // R7
  AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && data_phase && lsb_xfer && addr == TOP) |=> (addr == TOP)); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active)) |-> $stable(lsb_xfer)); // R9
  AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cs_active && data_phase)); // R10
endmodule

bind spi_rb_slave spi_rb_chk #(.AW(spi_rb_pkg::AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .spi_doe(spi_doe),
  .byte_done(byte_done), .data_phase(data_phase), .lsb_xfer(lsb_xfer),
  .wr_en(wr_en), .addr(addr)
);

// File: tb/tb_spi_rb_slave.sv
module tb_spi_rb_slave;
  localparam int HP = 8;
  localparam int WATCHDOG = 100000;
  // {write lsb-first, read lsb-first, address, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 1'b0, 7'h10, 8'h5A},
    {1'b1, 1'b1, 7'h11, 8'hC3},
    {1'b1, 1'b0, 7'h12, 8'h01},
    {1'b0, 1'b1, 7'h13, 8'h80},
    {1'b0, 1'b1, 7'h7F, 8'hE7},
    {1'b1, 1'b0, 7'h01, 8'h3C}
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic dout, doe;
  int   checks = 0, errors = 0, cyc = 0;
  logic cur_lsb = 1'b0;
  logic oe_bad = 1'b0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  always #5 clk = ~clk;

  spi_rb_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
    .spi_din(din), .spi_dout(dout), .spi_doe(doe)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nbits, input logic exp_oe, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx = cur_lsb ? i : 7 - i;
      din = tx[idx];
      idle(HP);
      rx[idx] = dout;
      if (doe !== exp_oe) oe_bad = 1'b1;
      sclk = 1'b1;
      idle(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic rw, input logic [6:0] a, input int n);
    logic [7:0] r;
    oe_bad = 1'b0;
    csn = 1'b0;
    idle(HP);
    shift_bits({rw, a}, 8, 1'b0, r);
    for (int k = 0; k < n; k++) begin
      shift_bits(txb[k], 8, rw, r);
      rxb[k] = r;
    end
    idle(HP);
    csn = 1'b1;
    idle(2 * HP);
    chk("R11", {7'd0, oe_bad}, 8'd0, "enable outside read data bits");
    chk("R11", {7'd0, doe}, 8'd0, "enable between frames");
  endtask

  task automatic set_mode(input logic lsb);
    txb[0] = lsb ? 8'h40 : 8'h00;
    xfer(1'b0, 7'h00, 1);
    cur_lsb = lsb;
  endtask

  task automatic write1(input logic [6:0] a, input logic [7:0] d);
    txb[0] = d;
    xfer(1'b0, a, 1);
  endtask

  task automatic read1(input logic [6:0] a);
    txb[0] = 8'h00;
    xfer(1'b1, a, 1);
  endtask

  initial begin
    logic [7:0] r;
    idle(4);
    chk("R1", {7'd0, doe}, 8'd0, "enable in reset");
    rst_n = 1'b1;
    idle(4);
    chk("R1", {7'd0, doe}, 8'd0, "enable after reset");
    read1(7'h10);
    chk("R1", rxb[0], 8'h00, "reg 0x10 after reset");
    read1(7'h7F);
    chk("R1", rxb[0], 8'h00, "reg 0x7F after reset");

    // table walk: write in one order, read back in the listed order
    foreach (VEC[v]) begin
      if (cur_lsb != VEC[v][16]) set_mode(VEC[v][16]);
      write1(VEC[v][14:8], VEC[v][7:0]);
      if (cur_lsb != VEC[v][15]) set_mode(VEC[v][15]);
      read1(VEC[v][14:8]);
      chk((VEC[v][16] | VEC[v][15]) ? "R2 R4" : "R2 R3", rxb[0], VEC[v][7:0], "table vector");
    end
    if (cur_lsb) set_mode(1'b0);

    // R5: descending burst, MSB-first
    txb[0] = 8'hAA; txb[1] = 8'hBB; txb[2] = 8'hCC;
    xfer(1'b0, 7'h22, 3);
    read1(7'h21);
    chk("R5", rxb[0], 8'hBB, "second burst byte at 0x21");
    read1(7'h20);
    chk("R5", rxb[0], 8'hCC, "third burst byte at 0x20");
    txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00;
    xfer(1'b1, 7'h22, 3);
    chk("R5", rxb[0], 8'hAA, "burst read byte 0");
    chk("R5", rxb[1], 8'hBB, "burst read byte 1");
    chk("R5", rxb[2], 8'hCC, "burst read byte 2");

    // R7: descending burst runs into 0x00 and holds
    txb[0] = 8'h9A; txb[1] = 8'h8B; txb[2] = 8'h11; txb[3] = 8'h22;
    xfer(1'b0, 7'h02, 4);
    for (int k = 0; k < 4; k++) txb[k] = 8'h00;
    xfer(1'b1, 7'h02, 4);
    chk("R5", rxb[0], 8'h9A, "reg 0x02");
    chk("R5", rxb[1], 8'h8B, "reg 0x01");
    chk("R7", rxb[2], 8'h22, "floor read 1");
    chk("R7", rxb[3], 8'h22, "floor read 2");
    read1(7'h7F);
    chk("R7", rxb[0], 8'hE7, "no wrap into 0x7F");
    set_mode(1'b0);

    // R6 and R8: ascending burst runs into 0x7F and holds
    set_mode(1'b1);
    txb[0] = 8'h5D; txb[1] = 8'h6E; txb[2] = 8'h7C; txb[3] = 8'h4B;
    xfer(1'b0, 7'h7D, 4);
    for (int k = 0; k < 4; k++) txb[k] = 8'h00;
    xfer(1'b1, 7'h7D, 4);
    chk("R6", rxb[0], 8'h5D, "reg 0x7D");
    chk("R6", rxb[1], 8'h6E, "reg 0x7E");
    chk("R8", rxb[2], 8'h4B, "ceiling read 1");
    chk("R8", rxb[3], 8'h4B, "ceiling read 2");
    read1(7'h00);
    chk("R8", rxb[0], 8'h40, "no wrap into 0x00");

    // R9: clear mode bit mid-frame; next byte still LSB-first and ascending
    txb[0] = 8'h00; txb[1] = 8'h01;
    xfer(1'b0, 7'h00, 2);
    cur_lsb = 1'b0;
    read1(7'h01);
    chk("R9", rxb[0], 8'h01, "byte after mode write");
    read1(7'h00);
    chk("R9", rxb[0], 8'h00, "mode register");

    // R10: abort partway through a data byte
    write1(7'h1F, 8'h3C);
    oe_bad = 1'b0;
    csn = 1'b0;
    idle(HP);
    shift_bits({1'b0, 7'h20}, 8, 1'b0, r);
    shift_bits(8'hA5, 8, 1'b0, r);
    shift_bits(8'hFF, 4, 1'b0, r);
    csn = 1'b1;
    idle(2 * HP);
    read1(7'h20);
    chk("R10", rxb[0], 8'hA5, "completed byte kept");
    read1(7'h1F);
    chk("R10", rxb[0], 8'h3C, "partial byte dropped");

    // R10: abort partway through an instruction, then a clean frame
    csn = 1'b0;
    idle(HP);
    shift_bits({1'b1, 7'h20}, 3, 1'b0, r);
    csn = 1'b1;
    idle(2 * HP);
    chk("R11", {7'd0, doe}, 8'd0, "enable after aborted instruction");
    read1(7'h20);
    chk("R10", rxb[0], 8'hA5, "bit counter cleared by abort");

    summary();
    $finish;
  end
endmodule